// File: doc/BRIEF.md
# Alert Line Responder With Address Arbitration

This block lets a management-bus target ask the host for attention. An internal event pulls the shared open-drain alert line low. The host finds out who is calling by reading one byte from the broadcast alert-response address, seven-bit 0x0C. Every device that is alerting answers at once with its own seven-bit address. The data line is wired-AND, so the devices arbitrate bit by bit, and the lowest address wins.

The responder watches the synchronized clock and data lines. It acknowledges the broadcast read only while its own alert is pending. It then shifts out its address. If a bit it has released reads back low, it drops off the line and stays pending, so the host will service it later. The alert is withdrawn only after a response that this device won completely, which the host then not-acknowledges and closes with STOP. Events that arrive while an alert is pending are held and raise a fresh alert once the current one has been served.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, alert_pull_o, sda_pull_o and serviced_o are all 0.
- R2: An event_i pulse while alert_pull_o is 0 sets alert_pull_o on the next clock, and it stays set until serviced.
- R3: The acknowledge slot (data low during the ninth clock) is driven only for the address byte 0x19 (0x0C followed by read bit 1), and only while an alert is pending; a write to 0x0C, a read of any other address, or a read with no alert pending is left unacknowledged.
- R4: After acknowledging, the responder sends OWN_ADDR most significant bit first, then an eighth bit of 1, with each bit changed only while SCL is low.
- R5: While sending, if a bit it releases (1) is sampled low on the rising SCL edge, the responder stops driving for the rest of the byte, so the line carries the lower of the competing bytes.
- R6: A lost arbitration leaves alert_pull_o set.
- R7: alert_pull_o clears, and serviced_o pulses for exactly one cycle, only on the STOP that follows a fully won response the host not-acknowledged; a host acknowledge of the response keeps the alert.
- R8: An event that arrives while an alert is pending is held; after the current alert is serviced, alert_pull_o is low for exactly one cycle and then set again. With no held event it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| event_i | input | 1 | Internal attention request, one cycle per event |
| alert_pull_o | output | 1 | 1 pulls the shared alert line low |
| sda_pull_o | output | 1 | 1 pulls the bus data line low |
| serviced_o | output | 1 | One-cycle pulse when the alert has been served |

## Verification
A bit counter that is off by one shows up as a shifted response byte, or as an acknowledge in the wrong slot, on the very next read from the host. A wrong arbitration decision shows up in the same byte, where the wired-AND value is not the lower address. It also shows up in the alert level after the following STOP. If the pending flag or the held event goes wrong, it shows up within a cycle or two of that STOP, as a missing or extra serviced pulse or as the wrong length of the low gap on the alert line. The sweep pits the responder against every other seven-bit competitor, so each arbitration bit position is exercised in both directions.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_SET,
    ST_ACK_HOLD,
    ST_SEND,
    ST_MACK,
    ST_DONE,
    ST_WAIT
  } resp_state_e;
endpackage

// File: rtl/smb_alert_busmon.sv
module smb_alert_busmon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edges while clock stays high mark bus conditions
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smb_alert_flag.sv
module smb_alert_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic done_i,
  output logic alert_o,
  output logic serviced_o
);
  logic alert_q, held_q, serv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alert_q <= 1'b0;
      held_q  <= 1'b0;
      serv_q  <= 1'b0;
    end else begin
      serv_q <= done_i;
      if (done_i) begin
        alert_q <= 1'b0;
        held_q  <= held_q | event_i;
      end else if (!alert_q) begin
        if (event_i || held_q) alert_q <= 1'b1;
        held_q <= 1'b0;
      end else if (event_i) begin
        held_q <= 1'b1;
      end
    end
  end

  assign alert_o    = alert_q;
  assign serviced_o = serv_q;
endmodule

// File: rtl/smb_alert_arb.sv
module smb_alert_arb #(
  parameter int          ADDR_W   = 7,
  parameter logic [6:0]  OWN_ADDR = 7'h2A,
  parameter logic [6:0]  ARA_ADDR = 7'h0C
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic pending_i,
  output logic sda_pull_o,
  output logic done_o
);
  import smb_alert_pkg::*;

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [BYTE_W-1:0] RX_MATCH = {ARA_ADDR[ADDR_W-1:0], 1'b1};
  localparam logic [BYTE_W-1:0] TX_BYTE  = {OWN_ADDR[ADDR_W-1:0], 1'b1};
  localparam logic [CNT_W-1:0]  LAST_RX  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0]  ALL_TX   = CNT_W'(BYTE_W);

  resp_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      pull_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise_i) begin
          rx_q <= {rx_q[BYTE_W-3:0], sda_i};
          if (cnt_q == LAST_RX) begin
            cnt_q <= '0;
            if ({rx_q, sda_i} == RX_MATCH && pending_i) state_q <= ST_ACK_SET;
            else                                          state_q <= ST_WAIT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ACK_SET: if (scl_fall_i) begin
          pull_q  <= 1'b1;
          state_q <= ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall_i) begin
          pull_q  <= ~TX_BYTE[BYTE_W-1];
          tx_q    <= TX_BYTE << 1;
          cnt_q   <= '0;
          state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (scl_rise_i) begin
            // released bit pulled low by a lower address: back off
            if (!pull_q && !sda_i) state_q <= ST_WAIT;
            else                   cnt_q   <= cnt_q + 1'b1;
          end else if (scl_fall_i) begin
            if (cnt_q == ALL_TX) begin
              pull_q  <= 1'b0;
              state_q <= ST_MACK;
            end else begin
              pull_q <= ~tx_q[BYTE_W-1];
              tx_q   <= tx_q << 1;
            end
          end
        end
        ST_MACK: if (scl_rise_i) state_q <= sda_i ? ST_DONE : ST_WAIT;
        default: ;
      endcase
      if (state_q == ST_SEND && scl_rise_i && !pull_q && !sda_i) pull_q <= 1'b0;
    end
  end

  assign sda_pull_o = pull_q;
  assign done_o     = stop_i && (state_q == ST_DONE);
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
  parameter int          ADDR_W   = 7,
  parameter logic [6:0]  OWN_ADDR = 7'h2A,
  parameter logic [6:0]  ARA_ADDR = 7'h0C
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic event_i,
  output logic alert_pull_o,
  output logic sda_pull_o,
  output logic serviced_o
);
  logic scl_rise, scl_fall, bus_start, bus_stop, done;

  smb_alert_busmon u_busmon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  smb_alert_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (event_i),
    .done_i     (done),
    .alert_o    (alert_pull_o),
    .serviced_o (serviced_o)
  );

  smb_alert_arb #(
    .ADDR_W   (ADDR_W),
    .OWN_ADDR (OWN_ADDR),
    .ARA_ADDR (ARA_ADDR)
  ) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_i),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .pending_i  (alert_pull_o),
    .sda_pull_o (sda_pull_o),
    .done_o     (done)
  );
endmodule

// File: rtl/smb_alert_chk.sv
module smb_alert_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic event_i,
  input logic alert_pull_o,
  input logic sda_pull_o,
  input logic serviced_o
);
  // R2
  event_raises_alert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && !alert_pull_o) |=> alert_pull_o);

  // R3
  drive_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> alert_pull_o);

  // R4
  drive_in_low_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_i);

  // R7
  release_only_served_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alert_pull_o) |-> serviced_o);

  // R7
  serviced_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serviced_o |=> !serviced_o);

  // R7
  serviced_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serviced_o |-> !alert_pull_o);
endmodule

bind smb_alert_responder smb_alert_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_i        (scl_i),
  .event_i      (event_i),
  .alert_pull_o (alert_pull_o),
  .sda_pull_o   (sda_pull_o),
  .serviced_o   (serviced_o)
);

// File: tb/tb_smb_alert_responder.sv
module tb_smb_alert_responder;
  localparam int         CLK_PERIOD = 10;
  localparam logic [6:0] OWN        = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic comp_low = 1'b0;
  logic event_in = 1'b0;
  logic alert_pull, sda_pull, serviced;
  logic sda_line;

  int checks = 0;
  int failures = 0;
  int serv_cnt = 0;
  int gap = 0;
  int last_gap = 0;
  logic prev_alert = 1'b0;
  logic finished = 1'b0;

  assign sda_line = host_sda & ~sda_pull & ~comp_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_alert_responder #(.OWN_ADDR(OWN)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl),
    .sda_i        (sda_line),
    .event_i      (event_in),
    .alert_pull_o (alert_pull),
    .sda_pull_o   (sda_pull),
    .serviced_o   (serviced)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_alert && !alert_pull) gap = 1;
      else if (!alert_pull) gap++;
      if (!prev_alert && alert_pull) last_gap = gap;
      if (serviced) serv_cnt++;
      prev_alert = alert_pull;
    end
  end

  task automatic hclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_event();
    event_in = 1'b1;
    hclk(1);
    event_in = 1'b0;
  endtask

  task automatic start_cond();
    host_sda = 1'b1; scl = 1'b1; hclk(4);
    host_sda = 1'b0; hclk(4);
    scl = 1'b0; hclk(4);
  endtask

  task automatic stop_cond();
    host_sda = 1'b0; hclk(4);
    scl = 1'b1; hclk(4);
    host_sda = 1'b1; hclk(4);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic acked);
    for (int i = 0; i < 8; i++) begin
      host_sda = b[7-i]; hclk(4);
      scl = 1'b1; hclk(4);
      scl = 1'b0;
    end
    host_sda = 1'b1; hclk(4);
    scl = 1'b1; hclk(2);
    acked = !sda_line; hclk(2);
    scl = 1'b0; hclk(1);
  endtask

  task automatic read_byte(input logic comp_en, input logic [7:0] comp,
                           input logic nack, output logic [7:0] got);
    logic lost;
    lost = 1'b0;
    for (int i = 0; i < 8; i++) begin
      comp_low = comp_en & !lost & !comp[7-i]; hclk(4);
      scl = 1'b1; hclk(2);
      got[7-i] = sda_line;
      if (comp_en && !lost && comp[7-i] && !sda_line) lost = 1'b1;
      hclk(2);
      scl = 1'b0;
    end
    comp_low = 1'b0;
    host_sda = nack; hclk(4);
    scl = 1'b1; hclk(4);
    scl = 1'b0; hclk(2);
  endtask

  task automatic service(input logic comp_en, input logic [7:0] comp, input logic nack,
                         output logic acked, output logic [7:0] got);
    start_cond();
    write_byte(8'h19, acked);
    if (acked) read_byte(comp_en, comp, nack, got);
    else got = 8'hFF;
    stop_cond();
    hclk(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] got;
    logic [7:0] own_b;
    int sc;
    own_b = {OWN, 1'b1};

    hclk(3);
    // R1 reset state
    check(alert_pull == 0, "R1 alert", alert_pull, 0);
    check(sda_pull == 0, "R1 sda", sda_pull, 0);
    check(serviced == 0, "R1 serviced", serviced, 0);
    rst_n = 1'b1;
    hclk(3);

    // R3 no ack while nothing pending
    service(1'b0, 8'h00, 1'b1, ack, got);
    check(ack == 0, "R3 idle read not acked", ack, 0);

    // R2 event raises alert
    pulse_event(); hclk(1);
    check(alert_pull == 1, "R2 alert after event", alert_pull, 1);
    hclk(20);
    check(alert_pull == 1, "R2 alert held", alert_pull, 1);

    // R3 write direction and foreign address
    start_cond(); write_byte(8'h18, ack); stop_cond();
    check(ack == 0, "R3 write to 0x0C not acked", ack, 0);
    start_cond(); write_byte(8'h17, ack); stop_cond();
    check(ack == 0, "R3 other address not acked", ack, 0);
    check(alert_pull == 1, "R3 alert kept", alert_pull, 1);

    // R4 R7 plain win
    sc = serv_cnt;
    service(1'b0, 8'h00, 1'b1, ack, got);
    check(ack == 1, "R3 pending read acked", ack, 1);
    check(got == own_b, "R4 response byte", got, own_b);
    check(alert_pull == 0, "R7 released", alert_pull, 0);
    check(serv_cnt == sc + 1, "R7 one serviced pulse", serv_cnt, sc + 1);

    // R7 host acknowledges response: alert kept
    pulse_event(); hclk(2);
    sc = serv_cnt;
    service(1'b0, 8'h00, 1'b0, ack, got);
    check(got == own_b, "R4 response byte again", got, own_b);
    check(alert_pull == 1, "R7 acked response keeps alert", alert_pull, 1);
    check(serv_cnt == sc, "R7 no serviced on host ack", serv_cnt, sc);

    // R8 held event
    pulse_event(); hclk(2);
    service(1'b0, 8'h00, 1'b1, ack, got);
    check(alert_pull == 1, "R8 re-armed after service", alert_pull, 1);
    check(last_gap == 1, "R8 one-cycle release gap", last_gap, 1);
    service(1'b0, 8'h00, 1'b1, ack, got);
    hclk(20);
    check(alert_pull == 0, "R8 stays low without held event", alert_pull, 0);

    // R5 R6 sweep against every other address
    for (int c = 0; c < 128; c++) begin
      logic [7:0] cb;
      logic [7:0] exp_b;
      if (c == int'(OWN)) continue;
      if (!alert_pull) begin pulse_event(); hclk(2); end
      cb = {c[6:0], 1'b1};
      exp_b = (cb < own_b) ? cb : own_b;
      service(1'b1, cb, 1'b1, ack, got);
      check(ack == 1, "R3 sweep ack", ack, 1);
      check(got == exp_b, "R5 arbitration byte", got, exp_b);
      check(alert_pull == (cb < own_b), "R6 alert after arbitration", alert_pull, (cb < own_b));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule